// File: doc/BRIEF.md
# Per-Channel Variable/Constant Delay Buffer

This block holds the bytes received on a time-division-multiplexed link and decides, for every output slot, which frame's copy of the chosen source byte is handed to the output fetch path. The incoming byte for each slot is stored in one of two frame banks. The active bank swaps at every frame boundary. A delay-mode bit that comes with each read picks one of two policies for that output slot.

Variable mode gives the shortest latency the timing allows. A source slot three or more slots ahead of the output slot is delivered after exactly that slot distance. A closer pair (distance 0, 1 or 2) is pushed out by one whole frame. Constant mode always takes the bank written in the previous frame. Every byte then waits one frame plus the slot offset, so groups of slots keep their mutual order and frame alignment.

The write and read counters are driven in step, one slot per `slotValid` cycle. Serialization and the programming of the per-slot source address and mode lie outside the block.

Top module: `slot_delay_buffer`

## Requirements
- R1: While `rst` is high, `outByte` is 0 on the next clock edge and stays 0 until a read takes place.
- R2: On each cycle with `slotValid` high, `inByte` is stored at `wrSlot` in the active bank. The active bank swaps after the cycle that writes slot NUM_SLOTS-1. A constant-mode read of slot 31 from source 31 therefore returns the byte written one frame earlier.
- R3: Variable mode, source slot below the read slot and distance (rdSlot - srcSlot) at least 3: the byte written in the current frame is returned. The delay equals the distance, including the minimum distance of 3.
- R4: Variable mode, source slot above the read slot and wrapped distance (rdSlot + 32 - srcSlot) at least 3: the byte from the previous frame is returned. The delay equals the wrapped distance, for example source 30 to output 1.
- R5: Variable mode, source slot equal to the read slot: the byte written one frame earlier is returned, a delay of 32 slots.
- R6: Variable mode, read slot 1 or 2 above the source slot with no wrap: the previous frame's byte is returned, a delay of 33 or 34 slots.
- R7: Variable mode, wrapped distance 1 or 2 (for example source 31 to output 0): the byte from two frames back in frame numbering is returned. This is still a delay of 33 or 34 slots.
- R8: Constant mode: for any source and read slot pair, the byte from the previous frame is returned.
- R9: The delay mode is taken per read cycle. Neighbouring slots that use the same source but different modes each follow their own policy.
- R10: `outByte` takes the fetched byte on the clock edge that ends a `slotValid` cycle. When `slotValid` is low, `outByte` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous reset, active high |
| slotValid | input | 1 | Marks a cycle carrying one time slot |
| wrSlot | input | 5 | Write channel counter |
| rdSlot | input | 5 | Read channel counter (output slot being fetched) |
| srcSlot | input | 5 | Source slot chosen for the output slot |
| constMode | input | 1 | 1 = constant delay, 0 = variable delay |
| inByte | input | 8 | Received byte for slot `wrSlot` |
| outByte | output | 8 | Selected byte for output slot `rdSlot` |

## Verification
Each stored byte encodes its frame number and slot number. A wrong bank therefore shows up as a frame mismatch, and a wrong address shows up as a slot mismatch. Source and read slot pairs are taken at distance 0, 1, 2, exactly 3 and larger. Each distance is tried with and without the frame wrap, and the wrap is what separates age zero, one and two. The same pairs are repeated in constant mode, which must always report the previous frame. Slots that alternate mode around one source, and a cycle with no valid slot, expose any mode decision that is latched or any output that is not held.

// File: rtl/slot_delay_pkg.sv
package slot_delay_pkg;

  // Strobes passed from the bank controller to the storage datapath
  typedef struct packed {
    logic wrEn;    // store inByte this cycle
    logic wrBank;  // bank receiving the write
    logic rdEn;    // capture a fetched byte into the output register
    logic rdBank;  // bank the fetch reads from
  } dlyStrobe_t;

endpackage

// File: rtl/slot_delay_ctrl.sv
module slot_delay_ctrl
  import slot_delay_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int MIN_GAP   = 3,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slotValid,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [SLOT_W-1:0] rdSlot,
  input  logic [SLOT_W-1:0] srcSlot,
  input  logic              constMode,
  output dlyStrobe_t        stb
);

  localparam int DLY_W = SLOT_W + 2;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [DLY_W-1:0]  SLOTS_EXT = DLY_W'(NUM_SLOTS);
  localparam logic [DLY_W-1:0]  GAP_EXT   = DLY_W'(MIN_GAP);

  logic             curBank;
  logic [DLY_W-1:0] rdExt;
  logic [DLY_W-1:0] srcExt;
  logic [DLY_W-1:0] slotDist;
  logic [DLY_W-1:0] slotDelay;
  logic             fromPrevFrame;
  logic             varBank;

  // Active bank flips once the last slot of a frame has been written
  always_ff @(posedge clk) begin
    if (rst) begin
      curBank <= 1'b0;
    end else if (slotValid && (wrSlot == LAST_SLOT)) begin
      curBank <= ~curBank;
    end
  end

  // Modular distance from source to output slot
  always_comb begin
    rdExt  = DLY_W'(rdSlot);
    srcExt = DLY_W'(srcSlot);
    if (rdExt >= srcExt) begin
      slotDist = rdExt - srcExt;
    end else begin
      slotDist = rdExt + SLOTS_EXT - srcExt;
    end
  end

  // Distances below the minimum gap wait one full frame more
  always_comb begin
    if (slotDist < GAP_EXT) begin
      slotDelay = slotDist + SLOTS_EXT;
    end else begin
      slotDelay = slotDist;
    end
  end

  // The source byte sits in the previous frame when the delay reaches back
  // past slot 0 but not past slot 0 of the previous frame; otherwise it is
  // either this frame's byte or a two-frame-old byte still unoverwritten,
  // both held in the active bank.
  always_comb begin
    fromPrevFrame = (slotDelay > rdExt) && (slotDelay <= rdExt + SLOTS_EXT);
    varBank       = fromPrevFrame ? ~curBank : curBank;
  end

  always_comb begin
    stb.wrEn   = slotValid;
    stb.wrBank = curBank;
    stb.rdEn   = slotValid;
    stb.rdBank = constMode ? ~curBank : varBank;
  end

endmodule

// File: rtl/slot_delay_dp.sv
module slot_delay_dp
  import slot_delay_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int NUM_BANKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  dlyStrobe_t        stb,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [SLOT_W-1:0] srcSlot,
  input  logic [DATA_W-1:0] inByte,
  output logic [DATA_W-1:0] outByte
);

  logic [DATA_W-1:0] bankRd [NUM_BANKS];
  logic [DATA_W-1:0] fetched;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] store [NUM_SLOTS];
    logic              bankSel;

    assign bankSel = (stb.wrBank == 1'(b));

    always_ff @(posedge clk) begin
      if (stb.wrEn && bankSel) begin
        store[wrSlot] <= inByte;
      end
    end

    assign bankRd[b] = store[srcSlot];
  end

  assign fetched = stb.rdBank ? bankRd[1] : bankRd[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      outByte <= '0;
    end else if (stb.rdEn) begin
      outByte <= fetched;
    end
  end

endmodule

// File: rtl/slot_delay_buffer.sv
module slot_delay_buffer
  import slot_delay_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 8,
  parameter int MIN_GAP   = 3,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slotValid,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [SLOT_W-1:0] rdSlot,
  input  logic [SLOT_W-1:0] srcSlot,
  input  logic              constMode,
  input  logic [DATA_W-1:0] inByte,
  output logic [DATA_W-1:0] outByte
);

  dlyStrobe_t stb;

  slot_delay_ctrl #(
    .NUM_SLOTS (NUM_SLOTS),
    .MIN_GAP   (MIN_GAP)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .slotValid (slotValid),
    .wrSlot    (wrSlot),
    .rdSlot    (rdSlot),
    .srcSlot   (srcSlot),
    .constMode (constMode),
    .stb       (stb)
  );

  slot_delay_dp #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .wrSlot  (wrSlot),
    .srcSlot (srcSlot),
    .inByte  (inByte),
    .outByte (outByte)
  );

endmodule

// File: rtl/slot_delay_buffer_chk.sv
module slot_delay_buffer_chk
  import slot_delay_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 8,
  parameter int MIN_GAP   = 3,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic              clk,
  input logic              rst,
  input logic              slotValid,
  input logic [SLOT_W-1:0] wrSlot,
  input logic [SLOT_W-1:0] rdSlot,
  input logic [SLOT_W-1:0] srcSlot,
  input logic              constMode,
  input logic [DATA_W-1:0] outByte,
  input dlyStrobe_t        stb
);

  int unsigned rdI;
  int unsigned srcI;
  int unsigned fwdGap;
  int unsigned wrapGap;

  always_comb begin
    rdI     = int'(rdSlot);
    srcI    = int'(srcSlot);
    fwdGap  = rdI - srcI;
    wrapGap = rdI + NUM_SLOTS - srcI;
  end

  AST_RESET_OUT: assert property (@(posedge clk)
    rst |=> (outByte == '0));  // R1

  AST_BANK_SWAP: assert property (@(posedge clk) disable iff (rst)
    (slotValid && wrSlot == SLOT_W'(NUM_SLOTS - 1)) |=> (stb.wrBank != $past(stb.wrBank)));  // R2

  AST_BANK_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(slotValid && wrSlot == SLOT_W'(NUM_SLOTS - 1)) |=> $stable(stb.wrBank));  // R2

  AST_VAR_SAME_FRAME: assert property (@(posedge clk) disable iff (rst)
    (slotValid && !constMode && srcI < rdI && fwdGap >= MIN_GAP) |-> (stb.rdBank == stb.wrBank));  // R3

  AST_VAR_WRAP_FAR: assert property (@(posedge clk) disable iff (rst)
    (slotValid && !constMode && srcI > rdI && wrapGap >= MIN_GAP) |-> (stb.rdBank != stb.wrBank));  // R4

  AST_VAR_SAME_SLOT: assert property (@(posedge clk) disable iff (rst)
    (slotValid && !constMode && srcI == rdI) |-> (stb.rdBank != stb.wrBank));  // R5

  AST_VAR_NEAR: assert property (@(posedge clk) disable iff (rst)
    (slotValid && !constMode && srcI < rdI && fwdGap < MIN_GAP) |-> (stb.rdBank != stb.wrBank));  // R6

  AST_VAR_WRAP_NEAR: assert property (@(posedge clk) disable iff (rst)
    (slotValid && !constMode && srcI > rdI && wrapGap < MIN_GAP) |-> (stb.rdBank == stb.wrBank));  // R7

  AST_CONST_PREV: assert property (@(posedge clk) disable iff (rst)
    (slotValid && constMode) |-> (stb.rdBank != stb.wrBank));  // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !slotValid |=> $stable(outByte));  // R10

endmodule

bind slot_delay_buffer slot_delay_buffer_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .DATA_W    (DATA_W),
  .MIN_GAP   (MIN_GAP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .slotValid (slotValid),
  .wrSlot    (wrSlot),
  .rdSlot    (rdSlot),
  .srcSlot   (srcSlot),
  .constMode (constMode),
  .outByte   (outByte),
  .stb       (stb)
);

// File: tb/slot_delay_buffer_bench.sv
module slot_delay_buffer_bench;

  localparam int SLOTS = 32;
  localparam int NVEC  = 15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slotValid = 1'b0;
  logic [4:0] wrSlot = '0;
  logic [4:0] rdSlot = '0;
  logic [4:0] srcSlot = '0;
  logic       constMode = 1'b0;
  logic [7:0] inByte = '0;
  logic [7:0] outByte;

  int checks = 0;
  int failures = 0;
  int frameNo = 0;
  int slotNo = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  slot_delay_buffer u_slot_delay_buffer (
    .clk       (clk),
    .rst       (rst),
    .slotValid (slotValid),
    .wrSlot    (wrSlot),
    .rdSlot    (rdSlot),
    .srcSlot   (srcSlot),
    .constMode (constMode),
    .inByte    (inByte),
    .outByte   (outByte)
  );

  // Vector fields: {rd[4:0], src[4:0], const, frameAge[1:0], reqTag[3:0]}
  localparam logic [16:0] VEC [NVEC] = '{
    {5'd10, 5'd4,  1'b0, 2'd0, 4'd3},  // R3 distance 6
    {5'd3,  5'd0,  1'b0, 2'd0, 4'd3},  // R3 minimum gap
    {5'd31, 5'd0,  1'b0, 2'd0, 4'd3},  // R3 distance 31
    {5'd1,  5'd30, 1'b0, 2'd1, 4'd4},  // R4 wrap gap 3
    {5'd5,  5'd20, 1'b0, 2'd1, 4'd4},  // R4 wrap gap 17
    {5'd7,  5'd7,  1'b0, 2'd1, 4'd5},  // R5 same slot
    {5'd8,  5'd7,  1'b0, 2'd1, 4'd6},  // R6 gap 1
    {5'd9,  5'd7,  1'b0, 2'd1, 4'd6},  // R6 gap 2
    {5'd0,  5'd31, 1'b0, 2'd2, 4'd7},  // R7 wrap gap 1
    {5'd1,  5'd31, 1'b0, 2'd2, 4'd7},  // R7 wrap gap 2
    {5'd0,  5'd30, 1'b0, 2'd2, 4'd7},  // R7 wrap gap 2 from 30
    {5'd10, 5'd4,  1'b1, 2'd1, 4'd8},  // R8 same pair as first
    {5'd2,  5'd31, 1'b1, 2'd1, 4'd8},  // R8 wrapped pair
    {5'd20, 5'd20, 1'b1, 2'd1, 4'd8},  // R8 same slot
    {5'd31, 5'd31, 1'b1, 2'd1, 4'd2}   // R2 last slot, previous bank
  };

  function automatic logic [7:0] pat(input int f, input int s);
    return {3'(f), 5'(s)};
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic drive(input int src, input bit mode, input bit valid);
    @(negedge clk);
    slotValid = valid;
    wrSlot    = 5'(slotNo);
    rdSlot    = 5'(slotNo);
    srcSlot   = 5'(src);
    constMode = mode;
    inByte    = pat(frameNo, slotNo);
    @(posedge clk);
    #2;
    if (valid) begin
      slotNo++;
      if (slotNo == SLOTS) begin
        slotNo = 0;
        frameNo++;
      end
    end
  endtask

  initial begin
    logic [7:0] exp;
    logic [7:0] held;
    repeat (3) @(posedge clk);
    #2;
    chk(outByte, 8'h00, "R1");
    @(negedge clk);
    rst = 1'b0;

    // Fill two frames
    for (int i = 0; i < 2 * SLOTS; i++) drive(0, 1'b0, 1'b1);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      int rd, src, age, tag;
      bit md;
      rd  = int'(VEC[v][16:12]);
      src = int'(VEC[v][11:7]);
      md  = VEC[v][6];
      age = int'(VEC[v][5:4]);
      tag = int'(VEC[v][3:0]);
      while (slotNo != rd) drive(0, 1'b0, 1'b1);
      exp = pat(frameNo - age, src);
      drive(src, md, 1'b1);
      chk(outByte, exp, $sformatf("R%0d vec%0d", tag, v));
    end

    // R9: alternate modes around one source
    while (slotNo != 12) drive(0, 1'b0, 1'b1);
    exp = pat(frameNo, 5);
    drive(5, 1'b0, 1'b1);
    chk(outByte, exp, "R9 variable");
    exp = pat(frameNo - 1, 5);
    drive(5, 1'b1, 1'b1);
    chk(outByte, exp, "R9 constant");
    exp = pat(frameNo, 5);
    drive(5, 1'b0, 1'b1);
    chk(outByte, exp, "R9 variable again");

    // R10: idle cycle holds the output, then the next slot updates it
    held = outByte;
    drive(20, 1'b1, 1'b0);
    chk(outByte, held, "R10 hold");
    exp = pat(frameNo, 6);
    drive(6, 1'b0, 1'b1);
    chk(outByte, exp, "R10 update");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule